// File: doc/BRIEF.md
# Write Precompensation Shifter

This block moves each pulse of a serial write-data stream a little earlier, leaves it where it is, or moves it a little later before it goes to a floppy drive. The shift compensates for the peak shift that closely packed flux transitions suffer on read-back. An upstream encoder decides which pulses need shifting and signals the direction on two preshift inputs that travel with each bit.

All pulses pass through one serial delay line clocked by a fast clock. One tap is picked per pulse: the shortest tap for early, a middle tap for nominal and a deep tap for late. Nominal pulses therefore carry a fixed built-in delay. The selected tap is inverted and registered to form the active-low drive output. With the default taps (0, 2 and 4 stages) and an 8 MHz clock, the shift step is 250 ns. Clocking the line at 16 MHz halves the step.

The selection is captured once per pulse, at its rising edge. It is then held until the pulse has cleared the deepest tap, so a pulse is never cut or merged by a change of tap.

Top module: `wpc_shifter`

## Requirements
- R1: While reset is asserted, and after it is released with the write input low, `wdata_n` is high and stays high. Reset clears the delay line, so no pulse that was in flight appears afterwards.
- R2: Preshift code 01 (early) selects tap TAP_EARLY (default 0). An input sample that is high at rising clock edge n drives `wdata_n` low from edge n+TAP_EARLY+1.
- R3: Preshift code 00 (nominal) selects tap TAP_NOM (default 2), so the output goes low from edge n+TAP_NOM+1.
- R4: Preshift code 10 (late) selects tap TAP_LATE (default 4), so the output goes low from edge n+TAP_LATE+1.
- R5: Preshift code 11 is treated as nominal, with the same timing as R3.
- R6: The preshift code is sampled only at the edge where the write input is first seen high after a low sample. Code changes at any other time have no effect on that pulse. A pulse of w high samples yields exactly w low output cycles.
- R7: At the rising edge of a new pulse, if any delay stage from 0 to TAP_LATE still holds a high sample, the previous selection is kept and the new code is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast shift clock |
| rst | input | 1 | Synchronous active-high reset |
| wdata_in | input | 1 | Serial write-data pulses, active high |
| preshift | input | 2 | Shift code: bit 0 early, bit 1 late |
| wdata_n | output | 1 | Precompensated write data, active low, registered |

## Verification
The assertions take for granted that the preshift code is a valid two-bit value when a pulse starts. They also assume that reset is synchronous, so that the selection register and the delay line move only on clock edges.

The sweep covers all four codes and pulse widths of one to three cycles, with gaps of twelve cycles. Pulse spacing is shortened on purpose only in the R7 case, where a second pulse starts while the first is still inside the line. A reference built from the stated tap latencies predicts the output in every cycle. Directed probes separately measure the edge-to-edge latency for each code.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    PS_NOM   = 2'd0,
    PS_EARLY = 2'd1,
    PS_LATE  = 2'd2
  } ps_mode_t;

  function automatic ps_mode_t decode_code(input logic [1:0] code);
    case (code)
      2'b01:   decode_code = PS_EARLY;
      2'b10:   decode_code = PS_LATE;
      default: decode_code = PS_NOM;
    endcase
  endfunction
endpackage

// File: rtl/wpc_delay_line.sv
module wpc_delay_line #(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  output logic [DEPTH-1:0] stages
);
  always_ff @(posedge clk) begin
    if (rst) stages[0] <= 1'b0;
    else     stages[0] <= din;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stages[i] <= 1'b0;
      else     stages[i] <= stages[i-1];
    end
  end
endmodule

// File: rtl/wpc_sel_hold.sv
module wpc_sel_hold
  import wpc_pkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int TAP_LATE = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             din,
  input  logic [1:0]       preshift,
  input  logic [DEPTH-1:0] stages,
  output ps_mode_t         mode
);
  logic rise;
  logic busy;

  assign rise = din & ~stages[0];
  assign busy = |stages[TAP_LATE:0];

  always_ff @(posedge clk) begin
    if (rst)               mode <= PS_NOM;
    else if (rise && !busy) mode <= decode_code(preshift);
  end

  // R7: while a pulse is still ahead of the deepest tap, the selection holds
  a_r7_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(mode));

  // R5: code 11 starts a pulse in nominal mode
  a_r5_code11_nominal: assert property (@(posedge clk) disable iff (rst)
    (rise && !busy && preshift == 2'b11) |=> (mode == PS_NOM));

  // R6: no change of selection without a pulse start
  a_r6_latch_on_rise: assert property (@(posedge clk) disable iff (rst)
    !rise |=> $stable(mode));
endmodule

// File: rtl/wpc_tap_mux.sv
module wpc_tap_mux
  import wpc_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int TAP_EARLY = 0,
  parameter int TAP_NOM   = 2,
  parameter int TAP_LATE  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DEPTH-1:0] stages,
  input  ps_mode_t         mode,
  output logic             wdata_n
);
  logic picked;

  always_comb begin
    case (mode)
      PS_EARLY: picked = stages[TAP_EARLY];
      PS_LATE:  picked = stages[TAP_LATE];
      default:  picked = stages[TAP_NOM];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) wdata_n <= 1'b1;
    else     wdata_n <= ~picked;
  end

  // R1: an empty delay line leaves the drive output inactive
  a_r1_idle_high: assert property (@(posedge clk) disable iff (rst)
    (stages == '0) |=> wdata_n);

  // R1: reset forces the output inactive on the next edge
  a_r1_reset_high: assert property (@(posedge clk)
    rst |=> wdata_n);
endmodule

// File: rtl/wpc_shifter.sv
module wpc_shifter
  import wpc_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int TAP_EARLY = 0,
  parameter int TAP_NOM   = 2,
  parameter int TAP_LATE  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wdata_in,
  input  logic [1:0] preshift,
  output logic       wdata_n
);
  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] stages;
  ps_mode_t         mode;

  initial begin
    if (!(TAP_EARLY < TAP_NOM && TAP_NOM < TAP_LATE && TAP_LATE <= LAST))
      $error("wpc_shifter: taps must rise strictly and fit the line");
  end

  wpc_delay_line #(.DEPTH(DEPTH)) u_line (
    .clk(clk), .rst(rst), .din(wdata_in), .stages(stages)
  );

  wpc_sel_hold #(.DEPTH(DEPTH), .TAP_LATE(TAP_LATE)) u_sel (
    .clk(clk), .rst(rst), .din(wdata_in), .preshift(preshift),
    .stages(stages), .mode(mode)
  );

  wpc_tap_mux #(
    .DEPTH(DEPTH), .TAP_EARLY(TAP_EARLY), .TAP_NOM(TAP_NOM), .TAP_LATE(TAP_LATE)
  ) u_mux (
    .clk(clk), .rst(rst), .stages(stages), .mode(mode), .wdata_n(wdata_n)
  );
endmodule

// File: tb/wpc_shifter_bench.sv
module wpc_shifter_bench;
  localparam int TE = 0, TN = 2, TL = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wdata_in = 1'b0;
  logic [1:0] preshift = 2'b00;
  logic       wdata_n;

  int    n_tests = 0, n_fail = 0;
  string tag = "R1";
  bit    live = 1'b0;

  // reference state built from the tap latencies in the requirements
  bit [7:0] hist = '0;
  int       ktap = TN;
  bit       exp_out = 1'b1;

  always #2 clk = ~clk;

  wpc_shifter u_wpc_shifter (
    .clk(clk), .rst(rst), .wdata_in(wdata_in), .preshift(preshift), .wdata_n(wdata_n)
  );

  function automatic int tap_of(input logic [1:0] c);
    if (c == 2'b01) return TE;
    if (c == 2'b10) return TL;
    return TN;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      hist = '0; ktap = TN; exp_out = 1'b1;
    end else begin
      exp_out = ~hist[ktap];
      if (wdata_in && !hist[0] && (hist[TL:0] == '0)) ktap = tap_of(preshift);
      hist = {hist[6:0], wdata_in};
    end
  end

  task automatic check(input string req, input bit act, input bit exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: wdata_n=%0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (live) check(tag, wdata_n, exp_out);

  task automatic pulse(input int w, input logic [1:0] code, input int gap,
                       input bit flip_mid);
    @(negedge clk); wdata_in = 1'b1; preshift = code;
    for (int i = 1; i < w; i++) begin
      @(negedge clk);
      if (flip_mid) preshift = ~code;
    end
    @(negedge clk); wdata_in = 1'b0; preshift = flip_mid ? ~code : code;
    for (int i = 1; i < gap; i++) @(negedge clk);
  endtask

  task automatic probe(input string req, input logic [1:0] code, input int exp_lat);
    int cnt, low;
    cnt = 0; low = 0;
    @(negedge clk); wdata_in = 1'b1; preshift = code;
    @(negedge clk); wdata_in = 1'b0; preshift = 2'b00; cnt = 1;
    while (wdata_n && cnt < 20) begin @(negedge clk); cnt++; end
    while (!wdata_n && low < 20) begin low++; @(negedge clk); end
    n_tests++;
    if (cnt != exp_lat) begin
      n_fail++;
      $display("FAIL %s: latency %0d expected %0d", req, cnt, exp_lat);
    end
    n_tests++;
    if (low != 1) begin
      n_fail++;
      $display("FAIL R6: low width %0d expected 1 (%s)", low, req);
    end
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", wdata_n, 1'b1);
    rst = 1'b0;
    live = 1'b1;
    tag = "R1";
    repeat (10) @(negedge clk);

    // sweep all codes and widths
    for (int c = 0; c < 4; c++) begin
      for (int w = 1; w <= 3; w++) begin
        if (c == 0) tag = "R3";
        else if (c == 1) tag = "R2";
        else if (c == 2) tag = "R4";
        else tag = "R5";
        pulse(w, c[1:0], 12, 1'b0);
      end
    end

    // code changes inside a pulse do not move it
    tag = "R6";
    for (int c = 0; c < 3; c++) pulse(3, c[1:0], 12, 1'b1);

    // new pulse while the first is still ahead of the deepest tap
    tag = "R7";
    pulse(2, 2'b10, 3, 1'b0);
    pulse(2, 2'b01, 12, 1'b0);
    pulse(1, 2'b01, 2, 1'b0);
    pulse(1, 2'b10, 12, 1'b0);

    // reset with a pulse in flight leaves nothing behind
    tag = "R1";
    pulse(2, 2'b10, 1, 1'b0);
    live = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    check("R1", wdata_n, 1'b1);
    rst = 1'b0;
    live = 1'b1;
    repeat (10) @(negedge clk);
    live = 1'b0;

    probe("R2", 2'b01, TE + 2);
    probe("R3", 2'b00, TN + 2);
    probe("R4", 2'b10, TL + 2);
    probe("R5", 2'b11, TN + 2);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule